// File: doc/BRIEF.md
# Speculative Load Alias Detector

This block guards code in which a binary translator has hoisted loads above earlier stores. Each hoisted load is issued as a protecting load: it claims one of eight protection slots and records there its byte address and access width. The store that the load was moved past is issued as a masked store, carrying one mask bit per slot. The block compares that store only against slots that are both selected by its mask and currently valid. If their byte ranges intersect, it raises an alias fault, so the surrounding code region can be rolled back and re-run in program order.

When the speculative region ends, on either a commit or a rollback, the block drops every protection at once. The memory access and any store buffering happen outside this block. The block only tracks the ranges and reports conflicts.

Top module: `alias_guard`

## Requirements
- R1: After reset no slot is valid, so a store with an all-ones mask raises no fault. The fault outputs reset to `faultPulse`=0 and `faultIdx`=0.
- R2: A protecting load (`protValid`=1) writes `protAddr` and `protSize` into slot `protIdx` and marks it valid. It replaces whatever that slot held before. The size code is the log2 of the byte count: 0=1, 1=2, 2=4, 3=8 bytes.
- R3: A masked store compares only against slots whose bit in `storeMask` is 1 (bit i selects slot i) and which are valid. A store with mask 0 never faults.
- R4: A store and a slot overlap when storeStart < slotEnd and slotStart < storeEnd, with each End = Start + byte count. Ranges that only touch do not fault.
- R5: A fault shows as `faultPulse`=1 for exactly the one cycle that follows a store cycle whose check found an overlap. No fault appears in any cycle that does not follow a store.
- R6: With a fault, `faultIdx` gives the lowest-numbered overlapping slot. Without a fault, `faultIdx` is 0.
- R7: `clearReq` (commit or rollback) invalidates every slot at that clock edge. A protecting load issued in the same cycle as `clearReq` is kept and is valid afterwards.
- R8: A store issued in the same cycle as `clearReq` never faults.
- R9: A store issued in the same cycle as a protecting load is compared against the slot contents from before that load.
- R10: Range ends are computed one bit wider than the address, so no range wraps past the top of the address space. A slot at 0xFFFFFFFC of 8 bytes does not overlap address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| protValid | input | 1 | Protecting load issued this cycle |
| protIdx | input | 3 | Slot claimed by the protecting load |
| protAddr | input | 32 | Start byte address of the load |
| protSize | input | 2 | Load size code (log2 bytes) |
| storeValid | input | 1 | Masked store issued this cycle |
| storeMask | input | 8 | Slots the store must be checked against |
| storeAddr | input | 32 | Start byte address of the store |
| storeSize | input | 2 | Store size code (log2 bytes) |
| clearReq | input | 1 | Commit or rollback: drop all protections |
| faultPulse | output | 1 | Alias fault, one cycle after the store |
| faultIdx | output | 3 | Lowest overlapping slot, 0 when idle |

## Verification
A slot whose valid bit, address or size is held wrongly can only show up at the ports through a masked store. It shows as a missing or extra `faultPulse`, or a wrong `faultIdx`, exactly one cycle after that store. The bench therefore pairs every protection pattern with stores whose ranges sit just inside, exactly adjacent to, and straddling each protected range. It also probes state after commit, after a slot is overwritten, and at the top of the address space, so that a stale or corrupted slot is exposed on the very next store.

// File: rtl/alias_guard_pkg.sv
package alias_guard_pkg;
  localparam int unsigned DefEntries = 8;
  localparam int unsigned DefAddrW   = 32;
  localparam int unsigned DefSizeW   = 2;

  // strobes from control to the slot datapath
  typedef struct packed {
    logic clearAll;
    logic writeEn;
    logic checkEn;
  } strobe_t;
endpackage

// File: rtl/alias_guard_ctrl.sv
module alias_guard_ctrl
  import alias_guard_pkg::*;
#(
  parameter int unsigned NumEntries = DefEntries,
  localparam int unsigned IdxW = $clog2(NumEntries)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  protValid,
  input  logic                  storeValid,
  input  logic                  clearReq,
  input  logic [NumEntries-1:0] hitVec,
  output strobe_t               strobes,
  output logic                  faultPulse,
  output logic [IdxW-1:0]       faultIdx
);
  logic            anyHit;
  logic [IdxW-1:0] lowIdx;

  always_comb begin
    strobes.clearAll = clearReq;
    strobes.writeEn  = protValid;
    strobes.checkEn  = storeValid && !clearReq;
  end

  // lowest matching slot wins
  always_comb begin
    anyHit = |hitVec;
    lowIdx = '0;
    for (int i = NumEntries - 1; i >= 0; i--) begin
      if (hitVec[i]) lowIdx = IdxW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultPulse <= 1'b0;
      faultIdx   <= '0;
    end else begin
      faultPulse <= strobes.checkEn && anyHit;
      faultIdx   <= (strobes.checkEn && anyHit) ? lowIdx : '0;
    end
  end
endmodule

// File: rtl/alias_guard_slots.sv
module alias_guard_slots
  import alias_guard_pkg::*;
#(
  parameter int unsigned NumEntries = DefEntries,
  parameter int unsigned AddrW      = DefAddrW,
  parameter int unsigned SizeW      = DefSizeW,
  localparam int unsigned IdxW = $clog2(NumEntries),
  localparam int unsigned EndW = AddrW + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobes,
  input  logic [IdxW-1:0]       protIdx,
  input  logic [AddrW-1:0]      protAddr,
  input  logic [SizeW-1:0]      protSize,
  input  logic [NumEntries-1:0] storeMask,
  input  logic [AddrW-1:0]      storeAddr,
  input  logic [SizeW-1:0]      storeSize,
  output logic [NumEntries-1:0] hitVec
);
  logic [NumEntries-1:0] slotValid;
  logic [AddrW-1:0]      slotAddr [NumEntries];
  logic [SizeW-1:0]      slotSize [NumEntries];
  logic [EndW-1:0]       storeLo;
  logic [EndW-1:0]       storeHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid <= '0;
      for (int i = 0; i < NumEntries; i++) begin
        slotAddr[i] <= '0;
        slotSize[i] <= '0;
      end
    end else begin
      if (strobes.clearAll) slotValid <= '0;
      if (strobes.writeEn) begin
        slotValid[protIdx] <= 1'b1;
        slotAddr[protIdx]  <= protAddr;
        slotSize[protIdx]  <= protSize;
      end
    end
  end

  assign storeLo = {1'b0, storeAddr};
  assign storeHi = storeLo + (EndW'(1) << storeSize);

  for (genvar g = 0; g < NumEntries; g++) begin : g_cmp
    logic [EndW-1:0] slotLo;
    logic [EndW-1:0] slotHi;
    assign slotLo    = {1'b0, slotAddr[g]};
    assign slotHi    = slotLo + (EndW'(1) << slotSize[g]);
    assign hitVec[g] = slotValid[g] && storeMask[g] &&
                       (storeLo < slotHi) && (slotLo < storeHi);
  end
endmodule

// File: rtl/alias_guard.sv
module alias_guard
  import alias_guard_pkg::*;
#(
  parameter int unsigned NumEntries = DefEntries,
  parameter int unsigned AddrW      = DefAddrW,
  parameter int unsigned SizeW      = DefSizeW,
  localparam int unsigned IdxW = $clog2(NumEntries)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  protValid,
  input  logic [IdxW-1:0]       protIdx,
  input  logic [AddrW-1:0]      protAddr,
  input  logic [SizeW-1:0]      protSize,
  input  logic                  storeValid,
  input  logic [NumEntries-1:0] storeMask,
  input  logic [AddrW-1:0]      storeAddr,
  input  logic [SizeW-1:0]      storeSize,
  input  logic                  clearReq,
  output logic                  faultPulse,
  output logic [IdxW-1:0]       faultIdx
);
  strobe_t               strobes;
  logic [NumEntries-1:0] hitVec;

  alias_guard_ctrl #(.NumEntries(NumEntries)) u_ctrl (
    .clk(clk), .rstN(rstN), .protValid(protValid), .storeValid(storeValid),
    .clearReq(clearReq), .hitVec(hitVec), .strobes(strobes),
    .faultPulse(faultPulse), .faultIdx(faultIdx)
  );

  alias_guard_slots #(.NumEntries(NumEntries), .AddrW(AddrW), .SizeW(SizeW)) u_slots (
    .clk(clk), .rstN(rstN), .strobes(strobes), .protIdx(protIdx),
    .protAddr(protAddr), .protSize(protSize), .storeMask(storeMask),
    .storeAddr(storeAddr), .storeSize(storeSize), .hitVec(hitVec)
  );
endmodule

// File: rtl/alias_guard_chk.sv
module alias_guard_chk #(
  parameter int unsigned NumEntries = 8,
  localparam int unsigned IdxW = $clog2(NumEntries)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  storeValid,
  input logic [NumEntries-1:0] storeMask,
  input logic                  clearReq,
  input logic                  faultPulse,
  input logic [IdxW-1:0]       faultIdx
);
  assert_fault_after_store_R5: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> $past(storeValid));

  assert_clear_store_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> !faultPulse);

  assert_empty_mask_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (storeValid && storeMask == '0) |=> !faultPulse);

  assert_idx_in_mask_R6: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> ((($past(storeMask) >> faultIdx) & NumEntries'(1)) != '0));

  assert_idle_idx_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    !faultPulse |-> faultIdx == '0);
endmodule

bind alias_guard alias_guard_chk #(.NumEntries(NumEntries)) u_chk (
  .clk(clk), .rstN(rstN), .storeValid(storeValid), .storeMask(storeMask),
  .clearReq(clearReq), .faultPulse(faultPulse), .faultIdx(faultIdx)
);

// File: tb/sim_alias_guard.sv
`timescale 1ns/1ps
module sim_alias_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        protValid = 1'b0;
  logic [2:0]  protIdx = '0;
  logic [31:0] protAddr = '0;
  logic [1:0]  protSize = '0;
  logic        storeValid = 1'b0;
  logic [7:0]  storeMask = '0;
  logic [31:0] storeAddr = '0;
  logic [1:0]  storeSize = '0;
  logic        clearReq = 1'b0;
  logic        faultPulse;
  logic [2:0]  faultIdx;

  int checks = 0;
  int fails = 0;
  int spurious = 0;
  bit finished = 1'b0;
  bit       expFQ[$];
  bit [2:0] expIQ[$];
  string    reqQ[$];

  always #2 clk = ~clk;

  alias_guard u0 (
    .clk(clk), .rstN(rstN), .protValid(protValid), .protIdx(protIdx),
    .protAddr(protAddr), .protSize(protSize), .storeValid(storeValid),
    .storeMask(storeMask), .storeAddr(storeAddr), .storeSize(storeSize),
    .clearReq(clearReq), .faultPulse(faultPulse), .faultIdx(faultIdx)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus; a store pushes its expected outcome
  task automatic cyc(bit pv, bit [2:0] pi, bit [31:0] pa, bit [1:0] ps,
                     bit sv, bit [7:0] sm, bit [31:0] sa, bit [1:0] ss,
                     bit clr, bit expF, bit [2:0] expI, string req);
    protValid = pv; protIdx = pi; protAddr = pa; protSize = ps;
    storeValid = sv; storeMask = sm; storeAddr = sa; storeSize = ss;
    clearReq = clr;
    if (sv) begin
      expFQ.push_back(expF);
      expIQ.push_back(expI);
      reqQ.push_back(req);
    end
    @(negedge clk);
    protValid = 1'b0; storeValid = 1'b0; clearReq = 1'b0;
  endtask

  task automatic protect(bit [2:0] i, bit [31:0] a, bit [1:0] s);
    cyc(1, i, a, s, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic store(bit [31:0] a, bit [1:0] s, bit [7:0] m,
                       bit expF, bit [2:0] expI, string req);
    cyc(0, 0, 0, 0, 1, m, a, s, 0, expF, expI, req);
  endtask

  // monitor: compare each store's result one cycle later
  initial begin
    forever begin
      bit saw;
      @(posedge clk);
      saw = rstN && storeValid;
      @(negedge clk);
      if (saw) begin
        if (expFQ.size() == 0) begin
          check("R5", "unexpected store result", 1, 0);
        end else begin
          bit f;
          bit [2:0] ix;
          string r;
          f = expFQ.pop_front();
          ix = expIQ.pop_front();
          r = reqQ.pop_front();
          check(r, "faultPulse", int'(faultPulse), int'(f));
          check(r, "faultIdx", int'(faultIdx), int'(ix));
        end
      end else if (rstN && faultPulse) begin
        spurious++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1", "reset faultPulse", int'(faultPulse), 0);
    check("R6", "reset faultIdx", int'(faultIdx), 0);

    store(32'h100, 3, 8'hFF, 0, 0, "R1");

    // R2, R4: slot 2 covers 0x100..0x103
    protect(2, 32'h100, 2);
    store(32'h103, 0, 8'h04, 1, 2, "R4");
    store(32'h104, 0, 8'hFF, 0, 0, "R4");
    store(32'h0FC, 2, 8'hFF, 0, 0, "R4");
    store(32'h0FE, 2, 8'hFF, 1, 2, "R4");
    // R3: mask excludes slot 2, or is empty
    store(32'h100, 0, 8'hFB, 0, 0, "R3");
    store(32'h100, 3, 8'h00, 0, 0, "R3");

    // R2 overwrite, R6 lowest index
    protect(5, 32'h100, 3);
    protect(2, 32'h200, 0);
    store(32'h101, 0, 8'hFF, 1, 5, "R2");
    store(32'h200, 0, 8'hFF, 1, 2, "R2");
    protect(1, 32'h104, 0);
    store(32'h104, 0, 8'hFF, 1, 1, "R6");
    store(32'h104, 0, 8'hDF, 1, 1, "R6");
    store(32'h104, 0, 8'hFD, 1, 5, "R6");

    // R5: back-to-back faulting stores, then a quiet one
    store(32'h200, 0, 8'hFF, 1, 2, "R5");
    store(32'h107, 0, 8'hFF, 1, 5, "R5");
    store(32'h300, 0, 8'hFF, 0, 0, "R5");

    // R9: store in same cycle as the protect sees old contents
    cyc(1, 3, 32'h300, 0, 1, 8'h08, 32'h300, 0, 0, 0, 0, "R9");
    store(32'h300, 0, 8'h08, 1, 3, "R9");

    // R8: store alongside clear is quiet; R7: everything dropped after
    cyc(0, 0, 0, 0, 1, 8'hFF, 32'h100, 3, 1, 0, 0, "R8");
    store(32'h100, 3, 8'hFF, 0, 0, "R7");
    store(32'h300, 0, 8'hFF, 0, 0, "R7");
    protect(6, 32'h500, 0);
    cyc(1, 4, 32'h400, 1, 0, 0, 0, 0, 1, 0, 0, "");
    store(32'h401, 0, 8'hFF, 1, 4, "R7");
    store(32'h500, 0, 8'hFF, 0, 0, "R7");

    // R10: no wrap at the top of the address space
    protect(0, 32'hFFFF_FFFC, 3);
    store(32'h0, 2, 8'h01, 0, 0, "R10");
    store(32'hFFFF_FFFF, 0, 8'h01, 1, 0, "R10");
    store(32'hFFFF_FFF8, 2, 8'h01, 0, 0, "R10");

    repeat (3) @(negedge clk);
    check("R5", "pending store results", expFQ.size(), 0);
    check("R5", "faults without a store", spurious, 0);
    finished = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule